// File: doc/BRIEF.md
# Cascaded-Prescaler General-Purpose Timer

This block is an up-counting timer read and written through a small word-addressed register bus. The counter can be driven by either of two tick sources. One is a peripheral clock. The other is a slower oscillator whose ticks pass through a 4-bit prescaler and then the 12-bit main prescaler. The two dividers sit in series, so the oscillator path divides by the product of both ratios. Each source arrives as a single-cycle enable pulse in the system clock domain.

Software selects the source with a coded field and picks free-run or restart counting. It reads the counter at any time. A single compare channel raises a sticky status flag when the counter lands on the compare value. A self-clearing soft-reset bit returns the timer to a known state over a fixed number of cycles. Software polls that bit until it reads 0 before it programs the timer.

Top module: `gpt_timer`

## Requirements
- R1: After rst_ni the control, status and counter words all read 0.
- R2: Word addresses are fixed: 0 control, 1 prescale, 2 status, 4 compare, 9 counter. Reads of words 3, 5, 6, 7 and 8 return 0. Control bits are: 0 enable, [8:6] source code, 9 free-run, 10 oscillator enable, 15 soft reset. Control bits outside these read 0.
- R3: With source code 1 and the enable bit set, the counter advances once for every (P+1) peripheral ticks. P is prescale bits [11:0].
- R4: With source code 5 and both the enable and oscillator-enable bits set, the counter advances once for every (Q+1)*(P+1) oscillator ticks. Q is prescale bits [15:12].
- R5: No count occurs when the enable bit is clear. No count occurs for a source code other than 1 or 5. No count occurs for code 5 while the oscillator-enable bit is clear.
- R6: In free-run mode the counter wraps from its all-ones value to 0.
- R7: With free-run clear, a tick taken while the counter equals the compare value returns the counter to 0.
- R8: Status bit 0 is set by a tick that leaves the counter equal to the compare value. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: Writing 1 to control bit 15 makes that bit read 1 for exactly 4 clocks, after which it reads 0. The same write clears the counter, the status bit and every other control bit. The prescale and compare words keep their values.
- R10: Any write to the prescale word restarts both prescaler phases, so a full (P+1) ticks are needed before the next count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| per_tick_i | input | 1 | Peripheral clock enable pulse |
| osc_tick_i | input | 1 | Oscillator enable pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The bench randomises prescale values and tick counts on both sources and compares the counter with floor division by the single ratio or the product of the two ratios. A design that fed the oscillator straight into the counter, or that skipped the main divider, would report a count too large by the missing factor. Restart mode is tested with compare values of 0 and above. An off-by-one restart would leave residues modulo c instead of c+1, and a wrong flag condition would miss the case of compare 0. A narrow counter instance is driven through its wrap, where a compare of 0 must raise the flag. The soft-reset bit is read every cycle to catch a pulse that is 3 or 5 clocks long. A prescale rewrite in mid-phase is also tested, which catches a phase counter that keeps its stale count.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int MAIN_PW  = 12;
  localparam int OSC_PW   = 4;
  localparam int SWR_LEN  = 4;
  localparam int SWR_CW   = $clog2(SWR_LEN);

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STS  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd9;

  localparam int B_EN     = 0;
  localparam int B_SRC_LO = 6;
  localparam int B_FRR    = 9;
  localparam int B_OSCEN  = 10;
  localparam int B_SWR    = 15;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_PER  = 3'd1,
    SRC_OSC  = 3'd5
  } src_e;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] phase_q;
  logic         hit;

  assign hit    = (phase_q == div_i);
  assign tick_o = tick_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clr_i)   phase_q <= '0;
    else if (tick_i)  phase_q <= hit ? '0 : phase_q + W'(1);
  end
endmodule

// File: rtl/gpt_src_sel.sv
module gpt_src_sel
  import gpt_pkg::*;
(
  input  logic       en_i,
  input  logic [2:0] src_i,
  input  logic       osc_en_i,
  input  logic       per_tick_i,
  input  logic       osc_tick_i,
  input  logic       osc_div_tick_i,
  output logic       osc_gate_o,
  output logic       main_tick_o
);
  logic per_sel, osc_sel;

  assign per_sel     = en_i && (src_i == SRC_PER);
  assign osc_sel     = en_i && osc_en_i && (src_i == SRC_OSC);
  // oscillator prescaler only advances while its path is live
  assign osc_gate_o  = osc_sel & osc_tick_i;
  assign main_tick_o = (per_sel & per_tick_i) | (osc_sel & osc_div_tick_i);
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, nxt;

  assign nxt     = (restart_i && cnt_q == cmp_i) ? '0 : cnt_q + CNT_W'(1);
  assign match_o = tick_i && (nxt == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt;
  end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              per_tick_i,
  input  logic              osc_tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic               en_q, frr_q, osc_en_q, swr_q;
  logic [2:0]         src_q;
  logic [SWR_CW-1:0]  swr_cnt_q;
  logic [MAIN_PW-1:0] main_div_q;
  logic [OSC_PW-1:0]  osc_div_q;
  logic [CNT_W-1:0]   cmp_q, cnt;
  logic               sts_q;

  logic ctrl_wr, pre_wr, sts_clr, swr_wr, pre_clr;
  logic osc_gate, osc_div_tick, main_tick, cnt_tick, match;

  assign ctrl_wr = we_i && addr_i == A_CTRL && !swr_q;
  assign swr_wr  = ctrl_wr && wdata_i[B_SWR];
  assign pre_wr  = we_i && addr_i == A_PRE;
  assign sts_clr = we_i && addr_i == A_STS && wdata_i[0];
  assign pre_clr = swr_wr || pre_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; frr_q <= 1'b0; osc_en_q <= 1'b0; src_q <= '0;
      swr_q <= 1'b0; swr_cnt_q <= '0;
    end else if (swr_q) begin
      swr_cnt_q <= swr_cnt_q + SWR_CW'(1);
      if (swr_cnt_q == SWR_CW'(SWR_LEN-1)) swr_q <= 1'b0;
    end else if (swr_wr) begin
      en_q <= 1'b0; frr_q <= 1'b0; osc_en_q <= 1'b0; src_q <= '0;
      swr_q <= 1'b1; swr_cnt_q <= '0;
    end else if (ctrl_wr) begin
      en_q     <= wdata_i[B_EN];
      src_q    <= wdata_i[B_SRC_LO +: 3];
      frr_q    <= wdata_i[B_FRR];
      osc_en_q <= wdata_i[B_OSCEN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_div_q <= '0; osc_div_q <= '0; cmp_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_PRE) begin
        main_div_q <= wdata_i[MAIN_PW-1:0];
        osc_div_q  <= wdata_i[MAIN_PW +: OSC_PW];
      end
      if (addr_i == A_CMP) cmp_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sts_q <= 1'b0;
    else if (swr_wr)  sts_q <= 1'b0;
    else if (match)   sts_q <= 1'b1;
    else if (sts_clr) sts_q <= 1'b0;
  end

  gpt_prescaler #(.W(OSC_PW)) u_osc_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pre_clr),
    .tick_i(osc_gate), .div_i(osc_div_q), .tick_o(osc_div_tick)
  );

  gpt_src_sel u_sel (
    .en_i(en_q), .src_i(src_q), .osc_en_i(osc_en_q),
    .per_tick_i(per_tick_i), .osc_tick_i(osc_tick_i),
    .osc_div_tick_i(osc_div_tick), .osc_gate_o(osc_gate),
    .main_tick_o(main_tick)
  );

  gpt_prescaler #(.W(MAIN_PW)) u_main_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pre_clr),
    .tick_i(main_tick), .div_i(main_div_q), .tick_o(cnt_tick)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(swr_wr), .tick_i(cnt_tick),
    .restart_i(!frr_q), .cmp_i(cmp_q), .cnt_o(cnt), .match_o(match)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]         = en_q;
        rdata_o[B_SRC_LO +: 3] = src_q;
        rdata_o[B_FRR]        = frr_q;
        rdata_o[B_OSCEN]      = osc_en_q;
        rdata_o[B_SWR]        = swr_q;
      end
      A_PRE: begin
        rdata_o[MAIN_PW-1:0]      = main_div_q;
        rdata_o[MAIN_PW +: OSC_PW] = osc_div_q;
      end
      A_STS:   rdata_o[0] = sts_q;
      A_CMP:   rdata_o = DATA_W'(cmp_q);
      A_CNT:   rdata_o = DATA_W'(cnt);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             swr_q,
  input logic             swr_wr,
  input logic             en_q,
  input logic             frr_q,
  input logic             cnt_tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_q,
  input logic             sts_q,
  input logic             sts_clr
);
  logic [3:0] swr_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    swr_len_q <= '0;
    else if (swr_q) swr_len_q <= swr_len_q + 4'd1;
    else            swr_len_q <= '0;
  end

  assert_swr_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_q |-> swr_len_q < 4'd4);

  assert_swr_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swr_q && swr_len_q == 4'd3) |=> !swr_q);

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

  assert_disabled_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !swr_wr) |=> $stable(cnt));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick && !frr_q && cnt == cmp_q && !swr_wr) |=> cnt == '0);

  assert_sts_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !sts_clr && !swr_wr) |=> sts_q);
endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .swr_q(swr_q), .swr_wr(swr_wr),
  .en_q(en_q), .frr_q(frr_q), .cnt_tick(cnt_tick), .cnt(cnt),
  .cmp_q(cmp_q), .sts_q(sts_q), .sts_clr(sts_clr)
);

// File: tb/gpt_timer_tb_top.sv
`timescale 1ns/1ps
module gpt_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        per_tick = 1'b0, osc_tick = 1'b0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  int          n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  gpt_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_tick_i(per_tick), .osc_tick_i(osc_tick),
    .we_i(we_a), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a)
  );

  gpt_timer #(.CNT_W(8)) dut_w_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_tick_i(per_tick), .osc_tick_i(osc_tick),
    .we_i(we_b), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b)
  );

  localparam logic [31:0] C_EN = 32'h1, C_FRR = 32'h200, C_OSCEN = 32'h400;
  localparam logic [31:0] C_PER = 32'h40, C_OSC = 32'h140, C_SWR = 32'h8000;

  function automatic int exp_div(int n, int ratio);
    return n / ratio;
  endfunction

  function automatic int exp_restart(int n, int c);
    return n % (c + 1);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(bit b, logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr = a; wdata = d;
    if (b) we_b = 1'b1; else we_a = 1'b1;
    @(negedge clk_i);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(bit b, logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = b ? rdata_b : rdata_a;
  endtask

  task automatic soft_reset(bit b);
    logic [31:0] v;
    wr(b, 4'd0, C_SWR);
    for (int i = 0; i < 10; i++) begin
      rd(b, 4'd0, v);
      if (!v[15]) break;
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_per(int n);
    for (int i = 0; i < n; i++) begin
      per_tick = 1'b1; @(negedge clk_i);
      per_tick = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic pulse_osc(int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1; @(negedge clk_i);
      osc_tick = 1'b0; @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(0, 4'd0, v); check("R1 ctrl", v, 0);
    rd(0, 4'd2, v); check("R1 status", v, 0);
    rd(0, 4'd9, v); check("R1 counter", v, 0);

    // R2 map and field readback
    wr(0, 4'd0, 32'hFFFF_7FFE);
    rd(0, 4'd0, v); check("R2 ctrl fields", v, 32'h0000_07C0);
    wr(0, 4'd1, 32'hFFFF_ABCD);
    rd(0, 4'd1, v); check("R2 prescale", v, 32'h0000_ABCD);
    wr(0, 4'd4, 32'h1234_5678);
    rd(0, 4'd4, v); check("R2 compare", v, 32'h1234_5678);
    for (int a = 5; a < 9; a++) begin
      rd(0, 4'(a), v); check("R2 unused word", v, 0);
    end
    rd(0, 4'd3, v); check("R2 unused word 3", v, 0);

    // R9 soft reset timing and clearing
    wr(0, 4'd0, C_EN | C_PER | C_FRR);
    wr(0, 4'd1, 0);
    pulse_per(5);
    rd(0, 4'd9, v); check("R9 pre-reset count", v, 5);
    wr(0, 4'd0, C_SWR);
    for (int i = 0; i < 5; i++) begin
      rd(0, 4'd0, v); check("R9 swr bit", {31'd0, v[15]}, (i < 4) ? 1 : 0);
      @(negedge clk_i);
    end
    rd(0, 4'd0, v); check("R9 ctrl cleared", v, 0);
    rd(0, 4'd9, v); check("R9 counter cleared", v, 0);
    rd(0, 4'd4, v); check("R9 compare kept", v, 32'h1234_5678);

    // R3 / R4 random ratios
    for (int it = 0; it < 12; it++) begin
      int m, o, n;
      bit osc;
      m = $urandom_range(0, 5); o = $urandom_range(0, 3);
      n = $urandom_range(0, 60); osc = it[0];
      soft_reset(0);
      wr(0, 4'd1, (o << 12) | m);
      wr(0, 4'd4, 32'h0000_FFFF);
      if (osc) begin
        wr(0, 4'd0, C_EN | C_OSC | C_OSCEN | C_FRR);
        pulse_osc(n);
        rd(0, 4'd9, v); check("R4 osc cascade", v, exp_div(n, (o + 1) * (m + 1)));
      end else begin
        wr(0, 4'd0, C_EN | C_PER | C_FRR);
        pulse_per(n);
        rd(0, 4'd9, v); check("R3 peripheral", v, exp_div(n, m + 1));
      end
      rd(0, 4'd2, v); check("R8 no match", v, 0);
    end

    // R5 no-tick cases
    soft_reset(0); wr(0, 4'd1, 0);
    wr(0, 4'd0, C_EN | 32'h80 | C_FRR);
    pulse_per(6); pulse_osc(6);
    rd(0, 4'd9, v); check("R5 unused code", v, 0);
    wr(0, 4'd0, C_EN | C_OSC | C_FRR);
    pulse_osc(6);
    rd(0, 4'd9, v); check("R5 osc not enabled", v, 0);
    wr(0, 4'd0, C_PER | C_FRR);
    pulse_per(6);
    rd(0, 4'd9, v); check("R5 timer disabled", v, 0);

    // R10 prescale rewrite restarts phase
    soft_reset(0); wr(0, 4'd1, 3);
    wr(0, 4'd0, C_EN | C_PER | C_FRR);
    pulse_per(2);
    wr(0, 4'd1, 3);
    pulse_per(3);
    rd(0, 4'd9, v); check("R10 phase restarted", v, 0);
    pulse_per(1);
    rd(0, 4'd9, v); check("R10 full period", v, 1);

    // R7 / R8 restart mode with random compare
    for (int it = 0; it < 6; it++) begin
      int c, n;
      c = $urandom_range(1, 5); n = $urandom_range(0, 30);
      soft_reset(0); wr(0, 4'd1, 0); wr(0, 4'd4, c);
      wr(0, 4'd0, C_EN | C_PER);
      pulse_per(n);
      rd(0, 4'd9, v); check("R7 restart count", v, exp_restart(n, c));
      rd(0, 4'd2, v); check("R8 flag", v, (n >= c) ? 1 : 0);
    end
    soft_reset(0); wr(0, 4'd4, 0);
    wr(0, 4'd0, C_EN | C_PER);
    pulse_per(3);
    rd(0, 4'd9, v); check("R7 compare zero", v, 0);
    rd(0, 4'd2, v); check("R8 compare zero flag", v, 1);
    // R8 write-one-to-clear
    wr(0, 4'd0, C_PER);
    wr(0, 4'd2, 0);
    rd(0, 4'd2, v); check("R8 write 0 ignored", v, 1);
    wr(0, 4'd2, 1);
    rd(0, 4'd2, v); check("R8 write 1 clears", v, 0);

    // R6 wrap on narrow instance
    soft_reset(1); wr(1, 4'd1, 0);
    wr(1, 4'd0, C_EN | C_PER | C_FRR);
    pulse_per(256);
    rd(1, 4'd9, v); check("R6 wrap to zero", v, 0);
    rd(1, 4'd2, v); check("R8 match at wrap", v, 1);
    pulse_per(2);
    rd(1, 4'd9, v); check("R6 after wrap", v, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule